// File: doc/BRIEF.md
# Segment Register Descriptor Cache

This block models one segment register. The register has two parts: a selector that software can see, and a hidden copy of the segment descriptor that the selector names. When a new selector is loaded, the block takes the descriptor index from the selector's upper bits. It reads the 64-bit descriptor from the descriptor table through a simple read port, rebuilds the split base and limit fields, and stores them. Every later translation adds the 32-bit offset to the stored base. It does not touch the table again.

Because translations use the stored copy, a change to a table entry has no effect until the selector is loaded again. A selector whose index lies past the end of the table raises a one-cycle fault, and the register keeps its old state. Index 0 is the null descriptor. Loading it reads nothing from the table, and any translation made through it is flagged.

Top module: `seg_cache`

## Requirements
- R1: After reset, `busy_o` is 0, `xl_ready_o` is 1, `sel_o` is 0, `base_o` and `limit_o` are 0, `xl_valid_o` is 0, and the stored descriptor is null.
- R2: The descriptor index is `load_sel_i[15:3]`. When a load with a non-zero, in-range index is accepted, the block raises `rd_req_o` in the next cycle with `rd_idx_o` equal to that index. Both stay steady until the cycle in which `rd_valid_i` is high.
- R3: The descriptor word is packed from bit 0 upward as follows:
  - bits [15:0]: limit low
  - bits [31:16]: base low
  - bits [39:32]: base middle
  - bits [47:40]: access
  - bits [55:48]: limit-high/flags byte
  - bits [63:56]: base high

  The block builds `base_o = {base high, base middle, base low}` and `limit_o = {flags byte[3:0], limit low}`.
- R4: `busy_o` is high from the cycle after a table load is accepted until the cycle after `rd_valid_i`. While `busy_o` is high, `xl_ready_o` is low and translation requests produce no `xl_valid_o`.
- R5: A translation request accepted while `xl_ready_o` is high gives `xl_valid_o` for exactly one cycle, in the next cycle. In that cycle, `xl_addr_o` = stored base + `xl_off_i`, modulo 2^32.
- R6: Translations issue no table read. A table entry that changes after a load has no effect on translations until the selector is loaded again.
- R7: A load whose index is equal to or above `TBL_ENTRIES` causes the following:
  - `sel_fault_o` pulses for one cycle in the next cycle;
  - no table read is issued;
  - `sel_o`, `base_o` and `limit_o` keep their values.
- R8: A load with index 0 issues no table read. It updates `sel_o` in the next cycle and clears the base and limit. Translations made while the null descriptor is stored return `xl_valid_o` with `xl_null_o` high.
- R9: A load request made while `busy_o` is high is ignored.
- R10: Selector bits [2:0] do not change the index that is fetched, but `sel_o` holds the whole selector that was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load request for a new selector |
| load_sel_i | input | SEL_W | Selector to load |
| busy_o | output | 1 | Descriptor fetch in progress |
| sel_fault_o | output | 1 | One-cycle pulse for an index outside the table |
| rd_req_o | output | 1 | Table read request, held until data returns |
| rd_idx_o | output | SEL_W-3 | Table entry index to read |
| rd_valid_i | input | 1 | Table read data valid |
| rd_data_i | input | 64 | Descriptor word from the table |
| xl_req_i | input | 1 | Translation request |
| xl_off_i | input | 32 | Offset to translate |
| xl_ready_o | output | 1 | Translation request can be accepted |
| xl_valid_o | output | 1 | Translated address valid |
| xl_addr_o | output | 32 | Translated address |
| xl_null_o | output | 1 | Translation made through the null descriptor |
| sel_o | output | SEL_W | Selector currently loaded |
| base_o | output | 32 | Stored segment base |
| limit_o | output | 20 | Stored segment limit |

## Verification
The bench builds the block with `SEL_W` = 16 and `TBL_ENTRIES` = 8. With only eight entries, an ordinary selector such as 0x0048 (index 9) falls outside the table, so the fault path can be exercised. The bench's table model answers each read three cycles after the request. That keeps `busy_o` high long enough to drive translation requests and a second load into the fetch window. One table entry has a base of 0xFFFFF000, so an offset of 0x2000 shows that the address wraps modulo 2^32.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned DESC_W = 64;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LIM_W  = 20;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [7:0]        attr;
  } seg_desc_t;

  typedef enum logic {ST_IDLE, ST_READ} ld_state_e;
endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_pkg::*;
(
  input  logic [DESC_W-1:0] raw_i,
  output seg_desc_t         desc_o
);
  logic [15:0] lim_lo, base_lo;
  logic [7:0]  base_mid, attr, flags, base_hi;

  assign lim_lo   = raw_i[15:0];
  assign base_lo  = raw_i[31:16];
  assign base_mid = raw_i[39:32];
  assign attr     = raw_i[47:40];
  assign flags    = raw_i[55:48];
  assign base_hi  = raw_i[63:56];

  always_comb begin
    desc_o.base  = {base_hi, base_mid, base_lo};
    desc_o.limit = {flags[3:0], lim_lo};
    desc_o.attr  = attr;
  end
endmodule

// File: rtl/seg_load_fsm.sv
module seg_load_fsm
  import seg_pkg::*;
#(
  parameter int unsigned SEL_W       = 16,
  parameter int unsigned TBL_ENTRIES = 8192,
  localparam int unsigned IDX_W      = SEL_W - 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEL_W-1:0] load_sel_i,
  input  logic             rd_valid_i,
  input  seg_desc_t        fetched_i,
  output logic             busy_o,
  output logic             sel_fault_o,
  output logic             rd_req_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [SEL_W-1:0] sel_o,
  output seg_desc_t        desc_o,
  output logic             null_o
);
  ld_state_e        state_q;
  logic [SEL_W-1:0] pend_sel_q;
  logic [IDX_W-1:0] idx;
  logic             out_of_range;

  assign idx          = load_sel_i[SEL_W-1:3];
  assign out_of_range = 32'(idx) >= TBL_ENTRIES;
  assign busy_o       = (state_q == ST_READ);
  assign rd_req_o     = busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_sel_q  <= '0;
      rd_idx_o    <= '0;
      sel_fault_o <= 1'b0;
      sel_o       <= '0;
      desc_o      <= '0;
      null_o      <= 1'b1;
    end else begin
      sel_fault_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (load_i) begin
          if (out_of_range) begin
            sel_fault_o <= 1'b1;          // cache left untouched
          end else if (idx == '0) begin
            sel_o  <= load_sel_i;         // null: no table read
            desc_o <= '0;
            null_o <= 1'b1;
          end else begin
            state_q    <= ST_READ;
            rd_idx_o   <= idx;
            pend_sel_q <= load_sel_i;
          end
        end
        ST_READ: if (rd_valid_i) begin
          desc_o  <= fetched_i;
          sel_o   <= pend_sel_q;
          null_o  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              null_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              null_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      null_o  <= 1'b0;
    end else begin
      valid_o <= req_i;
      null_o  <= req_i & null_i;
      if (req_i) addr_o <= base_i + off_i;  // wraps modulo 2^ADDR_W
    end
  end
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_pkg::*;
#(
  parameter int unsigned SEL_W       = 16,
  parameter int unsigned TBL_ENTRIES = 8192
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [SEL_W-1:0]   load_sel_i,
  output logic               busy_o,
  output logic               sel_fault_o,
  output logic               rd_req_o,
  output logic [SEL_W-4:0]   rd_idx_o,
  input  logic               rd_valid_i,
  input  logic [63:0]        rd_data_i,
  input  logic               xl_req_i,
  input  logic [31:0]        xl_off_i,
  output logic               xl_ready_o,
  output logic               xl_valid_o,
  output logic [31:0]        xl_addr_o,
  output logic               xl_null_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic [31:0]        base_o,
  output logic [19:0]        limit_o
);
  seg_desc_t fetched, cached;
  logic      cached_null;

  seg_desc_unpack u_unpack (
    .raw_i  (rd_data_i),
    .desc_o (fetched)
  );

  seg_load_fsm #(.SEL_W(SEL_W), .TBL_ENTRIES(TBL_ENTRIES)) u_load (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_sel_i  (load_sel_i),
    .rd_valid_i  (rd_valid_i),
    .fetched_i   (fetched),
    .busy_o      (busy_o),
    .sel_fault_o (sel_fault_o),
    .rd_req_o    (rd_req_o),
    .rd_idx_o    (rd_idx_o),
    .sel_o       (sel_o),
    .desc_o      (cached),
    .null_o      (cached_null)
  );

  assign xl_ready_o = ~busy_o;

  seg_addr_gen u_agen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (xl_req_i & xl_ready_o),
    .off_i   (xl_off_i),
    .base_i  (cached.base),
    .null_i  (cached_null),
    .valid_o (xl_valid_o),
    .addr_o  (xl_addr_o),
    .null_o  (xl_null_o)
  );

  assign base_o  = cached.base;
  assign limit_o = cached.limit;
endmodule

// File: rtl/seg_cache_chk.sv
module seg_cache_chk #(
  parameter int unsigned SEL_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             busy_o,
  input logic             sel_fault_o,
  input logic             rd_req_o,
  input logic [SEL_W-4:0] rd_idx_o,
  input logic             rd_valid_i,
  input logic             xl_req_i,
  input logic [31:0]      xl_off_i,
  input logic             xl_ready_o,
  input logic             xl_valid_o,
  input logic [31:0]      xl_addr_o,
  input logic [31:0]      base_o
);
  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_idx_o)));

  a_r4_busy_until_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rd_valid_i) |=> busy_o);

  a_r4_no_xl_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && xl_req_i) |=> !xl_valid_o);

  a_r5_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_req_i && xl_ready_o) |=> (xl_valid_o && xl_addr_o == $past(32'(base_o + xl_off_i))));

  a_r5_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xl_req_i && xl_ready_o) |=> !xl_valid_o);

  a_r6_base_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !load_i) |=> $stable(base_o));

  a_r7_fault_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_fault_o |-> (!rd_req_o && !busy_o && $stable(base_o)));
endmodule

bind seg_cache seg_cache_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .busy_o      (busy_o),
  .sel_fault_o (sel_fault_o),
  .rd_req_o    (rd_req_o),
  .rd_idx_o    (rd_idx_o),
  .rd_valid_i  (rd_valid_i),
  .xl_req_i    (xl_req_i),
  .xl_off_i    (xl_off_i),
  .xl_ready_o  (xl_ready_o),
  .xl_valid_o  (xl_valid_o),
  .xl_addr_o   (xl_addr_o),
  .base_o      (base_o)
);

// File: tb/seg_cache_test.sv
`timescale 1ns/1ps
module seg_cache_test;
  localparam int SEL_W = 16;
  localparam int NENT  = 8;
  localparam int LAT   = 3;

  logic clk = 0, rst_n = 0;
  logic load = 0, rd_valid = 0, xl_req = 0;
  logic [SEL_W-1:0] load_sel = '0;
  logic [63:0] rd_data = '0;
  logic [31:0] xl_off = '0;
  logic busy, fault, rd_req, xl_ready, xl_valid, xl_null;
  logic [SEL_W-4:0] rd_idx;
  logic [31:0] xl_addr, base;
  logic [19:0] limit;
  logic [SEL_W-1:0] sel;

  logic [63:0] tbl [NENT];
  int n_chk = 0, n_fail = 0, n_reads = 0, lat_cnt = 0, wd = 0;

  always #4 clk = ~clk;

  seg_cache #(.SEL_W(SEL_W), .TBL_ENTRIES(NENT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_sel_i(load_sel),
    .busy_o(busy), .sel_fault_o(fault), .rd_req_o(rd_req), .rd_idx_o(rd_idx),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .xl_req_i(xl_req), .xl_off_i(xl_off),
    .xl_ready_o(xl_ready), .xl_valid_o(xl_valid), .xl_addr_o(xl_addr), .xl_null_o(xl_null),
    .sel_o(sel), .base_o(base), .limit_o(limit));

  // table model: answers LAT cycles after request
  always @(negedge clk) begin
    if (rd_req && !rd_valid) begin
      if (lat_cnt == LAT - 1) begin
        rd_valid = 1; rd_data = tbl[rd_idx]; lat_cnt = 0; n_reads++;
      end else lat_cnt++;
    end else rd_valid = 0;
  end

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l, input logic [7:0] a, input logic [3:0] f);
    return {b[31:24], f, l[19:16], a, b[23:16], b[15:0], l[15:0]};
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_load(input logic [SEL_W-1:0] s);
    @(negedge clk); load = 1; load_sel = s;
    @(negedge clk); load = 0;
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
  endtask

  task automatic xlate(input logic [31:0] off, input logic [31:0] exp, input logic exp_null, input string r);
    int r0 = n_reads;
    @(negedge clk); xl_req = 1; xl_off = off;
    @(negedge clk); xl_req = 0;
    chk(r, xl_valid, 1);
    chk(r, xl_addr, exp);
    chk(r, xl_null, exp_null);
    chk({r, " no read"}, rd_req, 0);
    @(negedge clk);
    chk({r, " one cycle"}, xl_valid, 0);
    chk({r, " reads"}, n_reads, r0);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0); chk("R1 ready", xl_ready, 1); chk("R1 sel", sel, 0);
    chk("R1 base", base, 0); chk("R1 limit", limit, 0); chk("R1 valid", xl_valid, 0);
  endtask

  task automatic t_fetch;
    int r0 = n_reads;
    @(negedge clk); load = 1; load_sel = 16'h0008;
    @(negedge clk); load = 0;
    chk("R2 req", rd_req, 1); chk("R2 idx", rd_idx, 1); chk("R4 busy", busy, 1);
    chk("R4 ready low", xl_ready, 0);
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    chk("R3 base", base, 32'h12345678); chk("R3 limit", limit, 20'h7ABCD);
    chk("R2 sel", sel, 16'h0008); chk("R2 one read", n_reads, r0 + 1);
  endtask

  task automatic t_stale;
    tbl[1] = mk(32'h0A000000, 20'h00100, 8'h92, 4'h0);
    xlate(32'h100, 32'h12345778, 0, "R6 stale");
    do_load(16'h0008);
    chk("R6 reload base", base, 32'h0A000000);
    xlate(32'h10, 32'h0A000010, 0, "R6 after reload");
  endtask

  task automatic t_wrap;
    do_load(16'h0010);
    chk("R3 limit2", limit, 20'hF0FFF);
    xlate(32'h2000, 32'h00001000, 0, "R5 wrap");
  endtask

  task automatic t_busy;
    @(negedge clk); load = 1; load_sel = 16'h0008;
    @(negedge clk); load = 1; load_sel = 16'h0010; xl_req = 1; xl_off = 32'h4;
    chk("R4 ready busy", xl_ready, 0);
    @(negedge clk); load = 0; xl_req = 0;
    chk("R4 no valid", xl_valid, 0);
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    chk("R9 sel kept", sel, 16'h0008); chk("R9 base", base, 32'h0A000000);
    @(negedge clk);
    chk("R9 no second fetch", busy, 0);
  endtask

  task automatic t_fault;
    int r0 = n_reads;
    @(negedge clk); load = 1; load_sel = 16'h0048;
    @(negedge clk); load = 0;
    chk("R7 fault", fault, 1); chk("R7 busy", busy, 0); chk("R7 req", rd_req, 0);
    @(negedge clk);
    chk("R7 pulse", fault, 0); chk("R7 sel", sel, 16'h0008);
    chk("R7 base", base, 32'h0A000000); chk("R7 reads", n_reads, r0);
  endtask

  task automatic t_null;
    int r0 = n_reads;
    @(negedge clk); load = 1; load_sel = 16'h0003;
    @(negedge clk); load = 0;
    chk("R8 busy", busy, 0); chk("R8 sel", sel, 16'h0003);
    chk("R8 base", base, 0); chk("R8 reads", n_reads, r0);
    xlate(32'h40, 32'h40, 1, "R8 null xlate");
  endtask

  task automatic t_lowbits;
    @(negedge clk); load = 1; load_sel = 16'h0017;
    @(negedge clk); load = 0;
    chk("R10 idx", rd_idx, 2);
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    chk("R10 sel", sel, 16'h0017); chk("R10 base", base, 32'hFFFFF000);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", wd);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) tbl[i] = '0;
    tbl[1] = mk(32'h12345678, 20'h7ABCD, 8'h9A, 4'hC);
    tbl[2] = mk(32'hFFFFF000, 20'hF0FFF, 8'h92, 4'h4);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fetch();
    xlate(32'h100, 32'h12345778, 0, "R5 add");
    t_stale();
    t_wrap();
    do_load(16'h0008);
    t_busy();
    t_fault();
    t_null();
    t_lowbits();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule